// File: doc/BRIEF.md
# Three-Multiplier Radix-2 Butterfly

This block is one pipelined radix-2 butterfly for signed fixed-point complex samples. Each accepted sample is a pair of complex operands `u` and `v` plus a complex twiddle `w`. For each sample the block returns the complex sum `u + v` and the rotated difference `(u - v) * w`. The twiddle is supplied on ports every cycle, so the caller keeps the coefficient storage and the addressing. Scheduling, stage scaling and twiddle generation belong to the surrounding pipeline.

The complex product uses a shared-term form that needs only three real multipliers. With the difference written as `a + jb` and the twiddle as `c + jd`, the term `a*(c - d)` is formed once. The real part is `d*(a - b) + a*(c - d)` and the imaginary part is `c*(a + b) - a*(c - d)`. The pipeline has three register stages: pre-add, multiply, and post-add with rounding and saturation. The sum path is delayed to stay in step with the difference path. Any result outside the output range is clamped to the nearest extreme; it never wraps.

Top module: `bfly3m_unit`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by exactly three clock cycles. A new sample may be accepted in every cycle.
- R2: For each accepted sample, `sum_re_o = u_re + v_re` and `sum_im_o = u_im + v_im`. Each is computed exactly and then clamped to [-2^(DATA_W-1), 2^(DATA_W-1)-1].
- R3: The twiddle is signed two's complement with TW_FRAC fractional bits, so 1.0 = 2^16 at the default parameters. With `p = (u - v) * w`, computed exactly as `re = dr*wr - di*wi` and `im = dr*wi + di*wr`, each difference output is `floor((p + 2^(TW_FRAC-1)) / 2^TW_FRAC)`, then clamped as in R4.
- R4: A difference result above 2^(DATA_W-1)-1 is output as 2^(DATA_W-1)-1. A result below -2^(DATA_W-1) is output as -2^(DATA_W-1). This holds at full-scale negative operands and twiddles.
- R5: The sum and difference of one sample are presented in the same cycle, the one in which `valid_o` is high for that sample.
- R6: While `valid_o` is low, all four data outputs keep the values of the last valid result. Input data presented with `valid_i` low has no effect on them.
- R7: While `rst_ni` is low, `valid_o` is 0 and all data outputs are 0.
- R8: Samples accepted in consecutive cycles are processed independently. Each result matches R2 and R3 for its own operands.
- R9: A twiddle of zero gives zero on both difference outputs, whatever `u` and `v` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample qualifier |
| u_re_i | input | DATA_W | Operand u, real part |
| u_im_i | input | DATA_W | Operand u, imaginary part |
| v_re_i | input | DATA_W | Operand v, real part |
| v_im_i | input | DATA_W | Operand v, imaginary part |
| tw_re_i | input | TW_W | Twiddle, real part |
| tw_im_i | input | TW_W | Twiddle, imaginary part |
| valid_o | output | 1 | Result qualifier |
| sum_re_o | output | DATA_W | Saturated real part of u+v |
| sum_im_o | output | DATA_W | Saturated imaginary part of u+v |
| dif_re_o | output | DATA_W | Rounded, saturated real part of (u-v)*w |
| dif_im_o | output | DATA_W | Rounded, saturated imaginary part of (u-v)*w |

## Verification
The bench drives full-scale negative operands and a twiddle of -2, where the difference grows past the output range. A design that wraps instead of clamping would flip the sign of those results. Sums of two maxima and two minima check the add path clamp. Mixed-sign and fractional twiddles are compared against a four-multiply reference. A mistake in the shared term, or in the rounding offset, shows up as an off-by-one or a sign error. Streams with no gaps and with gaps catch a sum path that is misaligned by a cycle. They also catch outputs that move while no result is valid.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int unsigned DATA_W_DEF  = 18;
  localparam int unsigned TW_W_DEF    = 18;
  localparam int unsigned TW_FRAC_DEF = 16;
  localparam int unsigned PIPE_LAT    = 3;
endpackage

// File: rtl/bfly_sat.sv
module bfly_sat #(
  parameter int unsigned IN_W  = 19,
  parameter int unsigned OUT_W = 18
) (
  input  logic signed [IN_W-1:0]  val_i,
  output logic signed [OUT_W-1:0] val_o
);
  localparam int unsigned EXT_W = IN_W - OUT_W + 1;
  localparam logic signed [IN_W-1:0] MAX_V = {{EXT_W{1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] MIN_V = {{EXT_W{1'b1}}, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (val_i > MAX_V)      val_o = MAX_V[OUT_W-1:0];
    else if (val_i < MIN_V) val_o = MIN_V[OUT_W-1:0];
    else                    val_o = val_i[OUT_W-1:0];
  end
endmodule

// File: rtl/bfly_preadd.sv
module bfly_preadd #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned TW_W   = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] u_re_i,
  input  logic signed [DATA_W-1:0] u_im_i,
  input  logic signed [DATA_W-1:0] v_re_i,
  input  logic signed [DATA_W-1:0] v_im_i,
  input  logic signed [TW_W-1:0]   tw_re_i,
  input  logic signed [TW_W-1:0]   tw_im_i,
  output logic signed [DATA_W:0]   sum_re_o,
  output logic signed [DATA_W:0]   sum_im_o,
  output logic signed [DATA_W:0]   a_o,
  output logic signed [DATA_W+1:0] amb_o,
  output logic signed [DATA_W+1:0] apb_o,
  output logic signed [TW_W-1:0]   c_o,
  output logic signed [TW_W-1:0]   d_o,
  output logic signed [TW_W:0]     cmd_o
);
  logic signed [DATA_W:0] dr, di;
  logic signed [DATA_W:0] sr, si;

  always_comb begin
    sr = u_re_i + v_re_i;
    si = u_im_i + v_im_i;
    dr = u_re_i - v_re_i;
    di = u_im_i - v_im_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_re_o <= '0;
      sum_im_o <= '0;
      a_o      <= '0;
      amb_o    <= '0;
      apb_o    <= '0;
      c_o      <= '0;
      d_o      <= '0;
      cmd_o    <= '0;
    end else if (en_i) begin
      sum_re_o <= sr;
      sum_im_o <= si;
      a_o      <= dr;
      amb_o    <= dr - di;
      apb_o    <= dr + di;
      c_o      <= tw_re_i;
      d_o      <= tw_im_i;
      cmd_o    <= tw_re_i - tw_im_i;
    end
  end
endmodule

// File: rtl/bfly_mult3.sv
module bfly_mult3 #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned TW_W   = 18,
  localparam int unsigned PROD_W = DATA_W + TW_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [DATA_W:0]   sum_re_i,
  input  logic signed [DATA_W:0]   sum_im_i,
  input  logic signed [DATA_W:0]   a_i,
  input  logic signed [DATA_W+1:0] amb_i,
  input  logic signed [DATA_W+1:0] apb_i,
  input  logic signed [TW_W-1:0]   c_i,
  input  logic signed [TW_W-1:0]   d_i,
  input  logic signed [TW_W:0]     cmd_i,
  output logic signed [DATA_W:0]   sum_re_o,
  output logic signed [DATA_W:0]   sum_im_o,
  output logic signed [PROD_W-1:0] m1_o,
  output logic signed [PROD_W-1:0] m2_o,
  output logic signed [PROD_W-1:0] m3_o
);
  // m3 = a*(c-d) is the shared term for both output parts
  logic signed [PROD_W-1:0] m1, m2, m3;

  always_comb begin
    m1 = d_i * amb_i;
    m2 = c_i * apb_i;
    m3 = a_i * cmd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_re_o <= '0;
      sum_im_o <= '0;
      m1_o     <= '0;
      m2_o     <= '0;
      m3_o     <= '0;
    end else if (en_i) begin
      sum_re_o <= sum_re_i;
      sum_im_o <= sum_im_i;
      m1_o     <= m1;
      m2_o     <= m2;
      m3_o     <= m3;
    end
  end
endmodule

// File: rtl/bfly_postsat.sv
module bfly_postsat #(
  parameter int unsigned DATA_W  = 18,
  parameter int unsigned TW_W    = 18,
  parameter int unsigned TW_FRAC = 16,
  localparam int unsigned PROD_W = DATA_W + TW_W + 2,
  localparam int unsigned ACC_W  = PROD_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [DATA_W:0]   sum_re_i,
  input  logic signed [DATA_W:0]   sum_im_i,
  input  logic signed [PROD_W-1:0] m1_i,
  input  logic signed [PROD_W-1:0] m2_i,
  input  logic signed [PROD_W-1:0] m3_i,
  output logic signed [DATA_W-1:0] sum_re_o,
  output logic signed [DATA_W-1:0] sum_im_o,
  output logic signed [DATA_W-1:0] dif_re_o,
  output logic signed [DATA_W-1:0] dif_im_o
);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (TW_FRAC - 1);

  logic signed [ACC_W-1:0]  acc    [2];
  logic signed [ACC_W-1:0]  scaled [2];
  logic signed [DATA_W:0]   sum_in [2];
  logic signed [DATA_W-1:0] dif_s  [2];
  logic signed [DATA_W-1:0] sum_s  [2];

  always_comb begin
    acc[0]    = m1_i + m3_i;
    acc[1]    = m2_i - m3_i;
    sum_in[0] = sum_re_i;
    sum_in[1] = sum_im_i;
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_comb scaled[g] = (acc[g] + HALF) >>> TW_FRAC;

    bfly_sat #(.IN_W(ACC_W), .OUT_W(DATA_W)) u_dif_sat (
      .val_i(scaled[g]),
      .val_o(dif_s[g])
    );

    bfly_sat #(.IN_W(DATA_W + 1), .OUT_W(DATA_W)) u_sum_sat (
      .val_i(sum_in[g]),
      .val_o(sum_s[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_re_o <= '0;
      sum_im_o <= '0;
      dif_re_o <= '0;
      dif_im_o <= '0;
    end else if (en_i) begin
      sum_re_o <= sum_s[0];
      sum_im_o <= sum_s[1];
      dif_re_o <= dif_s[0];
      dif_im_o <= dif_s[1];
    end
  end
endmodule

// File: rtl/bfly3m_unit.sv
module bfly3m_unit
  import bfly_pkg::*;
#(
  parameter int unsigned DATA_W  = DATA_W_DEF,
  parameter int unsigned TW_W    = TW_W_DEF,
  parameter int unsigned TW_FRAC = TW_FRAC_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] u_re_i,
  input  logic signed [DATA_W-1:0] u_im_i,
  input  logic signed [DATA_W-1:0] v_re_i,
  input  logic signed [DATA_W-1:0] v_im_i,
  input  logic signed [TW_W-1:0]   tw_re_i,
  input  logic signed [TW_W-1:0]   tw_im_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] sum_re_o,
  output logic signed [DATA_W-1:0] sum_im_o,
  output logic signed [DATA_W-1:0] dif_re_o,
  output logic signed [DATA_W-1:0] dif_im_o
);
  localparam int unsigned PROD_W = DATA_W + TW_W + 2;

  logic [PIPE_LAT-1:0] vld_q;

  logic signed [DATA_W:0]   s1_sum_re, s1_sum_im, s1_a;
  logic signed [DATA_W+1:0] s1_amb, s1_apb;
  logic signed [TW_W-1:0]   s1_c, s1_d;
  logic signed [TW_W:0]     s1_cmd;
  logic signed [DATA_W:0]   s2_sum_re, s2_sum_im;
  logic signed [PROD_W-1:0] s2_m1, s2_m2, s2_m3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[PIPE_LAT-2:0], valid_i};
  end

  assign valid_o = vld_q[PIPE_LAT-1];

  bfly_preadd #(.DATA_W(DATA_W), .TW_W(TW_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (valid_i),
    .u_re_i   (u_re_i),
    .u_im_i   (u_im_i),
    .v_re_i   (v_re_i),
    .v_im_i   (v_im_i),
    .tw_re_i  (tw_re_i),
    .tw_im_i  (tw_im_i),
    .sum_re_o (s1_sum_re),
    .sum_im_o (s1_sum_im),
    .a_o      (s1_a),
    .amb_o    (s1_amb),
    .apb_o    (s1_apb),
    .c_o      (s1_c),
    .d_o      (s1_d),
    .cmd_o    (s1_cmd)
  );

  bfly_mult3 #(.DATA_W(DATA_W), .TW_W(TW_W)) u_mul (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (vld_q[0]),
    .sum_re_i (s1_sum_re),
    .sum_im_i (s1_sum_im),
    .a_i      (s1_a),
    .amb_i    (s1_amb),
    .apb_i    (s1_apb),
    .c_i      (s1_c),
    .d_i      (s1_d),
    .cmd_i    (s1_cmd),
    .sum_re_o (s2_sum_re),
    .sum_im_o (s2_sum_im),
    .m1_o     (s2_m1),
    .m2_o     (s2_m2),
    .m3_o     (s2_m3)
  );

  bfly_postsat #(.DATA_W(DATA_W), .TW_W(TW_W), .TW_FRAC(TW_FRAC)) u_post (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (vld_q[1]),
    .sum_re_i (s2_sum_re),
    .sum_im_i (s2_sum_im),
    .m1_i     (s2_m1),
    .m2_i     (s2_m2),
    .m3_i     (s2_m3),
    .sum_re_o (sum_re_o),
    .sum_im_o (sum_im_o),
    .dif_re_o (dif_re_o),
    .dif_im_o (dif_im_o)
  );
endmodule

// File: rtl/bfly3m_chk.sv
module bfly3m_chk #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned TW_W   = 18
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic signed [DATA_W-1:0] u_re_i,
  input logic signed [DATA_W-1:0] u_im_i,
  input logic signed [DATA_W-1:0] v_re_i,
  input logic signed [DATA_W-1:0] v_im_i,
  input logic signed [TW_W-1:0]   tw_re_i,
  input logic signed [TW_W-1:0]   tw_im_i,
  input logic                     valid_o,
  input logic signed [DATA_W-1:0] sum_re_o,
  input logic signed [DATA_W-1:0] sum_im_o,
  input logic signed [DATA_W-1:0] dif_re_o,
  input logic signed [DATA_W-1:0] dif_im_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  function automatic logic signed [DATA_W-1:0] ref_add(logic signed [DATA_W-1:0] x,
                                                       logic signed [DATA_W-1:0] y);
    logic signed [DATA_W:0] s;
    s = x + y;
    if (s[DATA_W] != s[DATA_W-1]) ref_add = s[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}}
                                                     : {1'b0, {(DATA_W-1){1'b1}}};
    else ref_add = s[DATA_W-1:0];
  endfunction

  // R1
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q == 2'd3 |-> valid_o == $past(valid_i, 3));

  // R2
  sum_re_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && valid_o) |-> sum_re_o == ref_add($past(u_re_i, 3), $past(v_re_i, 3)));

  // R2
  sum_im_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && valid_o) |-> sum_im_o == ref_add($past(u_im_i, 3), $past(v_im_i, 3)));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && !valid_o) |->
      ($stable(sum_re_o) && $stable(sum_im_o) && $stable(dif_re_o) && $stable(dif_im_o)));

  // R7
  reset_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && sum_re_o == 0 && sum_im_o == 0 && dif_re_o == 0 && dif_im_o == 0));

  // R9
  zero_tw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && valid_o && $past(tw_re_i, 3) == 0 && $past(tw_im_i, 3) == 0)
      |-> (dif_re_o == 0 && dif_im_o == 0));
endmodule

bind bfly3m_unit bfly3m_chk #(.DATA_W(DATA_W), .TW_W(TW_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .u_re_i   (u_re_i),
  .u_im_i   (u_im_i),
  .v_re_i   (v_re_i),
  .v_im_i   (v_im_i),
  .tw_re_i  (tw_re_i),
  .tw_im_i  (tw_im_i),
  .valid_o  (valid_o),
  .sum_re_o (sum_re_o),
  .sum_im_o (sum_im_o),
  .dif_re_o (dif_re_o),
  .dif_im_o (dif_im_o)
);

// File: tb/sim_bfly3m_unit.sv
module sim_bfly3m_unit;
  localparam int DW = 18;
  localparam int TWW = 18;
  localparam int FW = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam longint ONE = 64'sd1 <<< FW;
  localparam longint MX = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint MN = -(64'sd1 <<< (DW - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic signed [DW-1:0] u_re, u_im, v_re, v_im;
  logic signed [TWW-1:0] tw_re, tw_im;
  logic valid_o;
  logic signed [DW-1:0] sum_re, sum_im, dif_re, dif_im;

  int checks = 0;
  int fails = 0;

  longint s_ur[64], s_ui[64], s_vr[64], s_vi[64], s_wr[64], s_wi[64];
  bit     s_v[64];
  longint last_sr = 0, last_si = 0, last_dr = 0, last_di = 0;
  logic [63:0] seed = 64'h1234_5678_9abc_def1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bfly3m_unit #(.DATA_W(DW), .TW_W(TWW), .TW_FRAC(FW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .u_re_i(u_re), .u_im_i(u_im), .v_re_i(v_re), .v_im_i(v_im),
    .tw_re_i(tw_re), .tw_im_i(tw_im),
    .valid_o(valid_o), .sum_re_o(sum_re), .sum_im_o(sum_im),
    .dif_re_o(dif_re), .dif_im_o(dif_im)
  );

  function automatic longint clamp(longint x);
    if (x > MX) return MX;
    if (x < MN) return MN;
    return x;
  endfunction

  function automatic longint rnd(longint p);
    return (p + (64'sd1 <<< (FW - 1))) >>> FW;
  endfunction

  function automatic longint next_rand();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return longint'($signed(seed[45:28]));
  endfunction

  task automatic cmp(string tag, int k, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s sample %0d %s: actual %0d expected %0d", tag, k, what, act, exp);
    end
  endtask

  task automatic set(int k, bit v, longint ur, longint ui, longint vr, longint vi,
                     longint wr, longint wi);
    s_v[k] = v; s_ur[k] = ur; s_ui[k] = ui; s_vr[k] = vr; s_vi[k] = vi;
    s_wr[k] = wr; s_wi[k] = wi;
  endtask

  task automatic check_slot(int k, string tag);
    longint dr, di;
    if (s_v[k]) begin
      dr = s_ur[k] - s_vr[k];
      di = s_ui[k] - s_vi[k];
      last_sr = clamp(s_ur[k] + s_vr[k]);
      last_si = clamp(s_ui[k] + s_vi[k]);
      last_dr = clamp(rnd(dr * s_wr[k] - di * s_wi[k]));
      last_di = clamp(rnd(dr * s_wi[k] + di * s_wr[k]));
    end
    cmp(tag, k, "valid_o (R1)", longint'(valid_o), longint'(s_v[k]));
    cmp(tag, k, "sum_re", longint'(sum_re), last_sr);
    cmp(tag, k, "sum_im", longint'(sum_im), last_si);
    cmp(tag, k, "dif_re", longint'(dif_re), last_dr);
    cmp(tag, k, "dif_im", longint'(dif_im), last_di);
  endtask

  // drive sample i at negedge i, its result is sampled at negedge i+3
  task automatic run_batch(int n, string tag);
    for (int i = 0; i < n + 3; i++) begin
      @(negedge clk);
      if (i >= 3) check_slot(i - 3, tag);
      if (i < n) begin
        valid_i = s_v[i];
        u_re = DW'(s_ur[i]); u_im = DW'(s_ui[i]);
        v_re = DW'(s_vr[i]); v_im = DW'(s_vi[i]);
        tw_re = TWW'(s_wr[i]); tw_im = TWW'(s_wi[i]);
      end else begin
        valid_i = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    cmp("R7", 0, "valid_o", longint'(valid_o), 0);
    cmp("R7", 0, "sum_re", longint'(sum_re), 0);
    cmp("R7", 0, "dif_im", longint'(dif_im), 0);
  endtask

  task automatic t_basic();
    set(0, 1, 1000, -2000, 300, 500, ONE, 0);
    set(1, 1, 1000, -2000, 300, 500, 0, -ONE);
    set(2, 1, -12345, 777, 4321, -999, 46341, -46341);
    set(3, 1, 3, 1, 0, 0, ONE / 2, ONE / 2);
    set(4, 1, -3, -1, 0, 0, ONE / 2, -ONE / 2);
    run_batch(5, "R3/R5");
  endtask

  task automatic t_sum_sat();
    set(0, 1, MX, MX, MX, 1, 0, 0);
    set(1, 1, MN, MN, MN, -1, 0, 0);
    set(2, 1, MX, MN, MN, MX, 0, 0);
    set(3, 1, MX, MN, 1, -1, 0, 0);
    run_batch(4, "R2");
  endtask

  task automatic t_dif_corners();
    set(0, 1, MN, MN, MX, MX, MN, MN);
    set(1, 1, MX, MX, MN, MN, MN, 0);
    set(2, 1, MN, MX, MX, MN, 0, MN);
    set(3, 1, MN, MN, MN, MN, MN, MN);
    set(4, 1, MN, 0, 0, 0, MX, MX);
    set(5, 1, MX, 0, MN, 0, ONE, 0);
    set(6, 1, MN, MN, 0, 0, MN, MX);
    run_batch(7, "R4");
  endtask

  task automatic t_zero_tw();
    set(0, 1, MX, MN, MN, MX, 0, 0);
    set(1, 1, 12345, -54321, -111, 222, 0, 0);
    run_batch(2, "R9");
  endtask

  task automatic t_stream();
    for (int k = 0; k < 40; k++)
      set(k, 1, next_rand(), next_rand(), next_rand(), next_rand(), next_rand(), next_rand());
    run_batch(40, "R8");
  endtask

  task automatic t_gaps();
    for (int k = 0; k < 30; k++)
      set(k, bit'((k % 3) == 0), next_rand(), next_rand(), next_rand(), next_rand(),
          next_rand(), next_rand());
    run_batch(30, "R6");
  endtask

  initial begin
    u_re = '0; u_im = '0; v_re = '0; v_im = '0; tw_re = '0; tw_im = '0;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_basic();
    t_sum_sat();
    t_dif_corners();
    t_zero_tw();
    t_stream();
    t_gaps();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule